// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from a set of internal sources and turns them into one vectored request toward the CPU. Source index 0 is the software source raised by an address-break event; indices 1 to 38 belong to the on-chip peripherals. A source is pending only while both its status flag and its enable bit are 1. Sources are grouped into modules of a fixed size. Each module carries a one-bit control level, and the CPU side has one mask bit.

Arbitration has two tiers. First, a pending source in a level-1 module beats any source in a level-0 module. Then, among the candidates at the winning level, the lowest source index wins, both between modules and inside a module. A per-source select bit sends a source to the data-transfer controller instead. A source sent this way is left out of CPU arbitration and produces a trigger pulse that neither the mask nor the levels affect. All outputs are registered.

Top module: `pic_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `irq_req` is 0, `irq_vec` is 0 and every bit of `xfer_trig` is 0.
- R2: Source i is pending only when `src_flag[i]` and `src_en[i]` are both 1. A flag without its enable, or an enable without its flag, never raises `irq_req`.
- R3: Source i belongs to module i / 4 (integer division), and `mod_level[m]` is that module's level. A CPU candidate in a level-1 module wins over every candidate in a level-0 module, whatever the indices.
- R4: Among CPU candidates at the same level, the lowest source index wins. This holds between modules and between sources of the same module.
- R5: When `cpu_mask` is 1, only sources in level-1 modules are CPU candidates. When it is 0, every pending source that is not routed to the transfer controller is a candidate.
- R6: A pending source with `xfer_sel[i]` = 1 is never reported on `irq_vec` and never raises `irq_req` on its own.
- R7: `xfer_trig[i]` is 1 exactly one cycle after `src_flag[i]`, `src_en[i]` and `xfer_sel[i]` were all 1. It does not depend on `cpu_mask` or `mod_level`.
- R8: `irq_req` and `irq_vec` change only on a clock edge. They reflect the inputs sampled at the previous edge, which is one cycle of latency.
- R9: When there is no CPU candidate, `irq_req` is 0 in the next cycle and `irq_vec` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_flag | input | NUM_SRC | Per-source status flags |
| src_en | input | NUM_SRC | Per-source enable bits |
| xfer_sel | input | NUM_SRC | 1 routes the source to the transfer controller |
| mod_level | input | NUM_MOD | Per-module control level (1 = high) |
| cpu_mask | input | 1 | 1 lets only level-1 modules reach the CPU |
| irq_req | output | 1 | Registered CPU interrupt request |
| irq_vec | output | VEC_W | Registered index of the winning source |
| xfer_trig | output | NUM_SRC | Registered per-source transfer-controller triggers |

## Verification
The bench goes after the places where the two tiers of arbitration meet. In one case a high-index level-1 source competes with a low-index level-0 source; a picker that looks at index alone would report the low index. In another, two sources of the same module are pending together. It sets the mask with only level-0 work pending, where a design that ignored the mask would still raise the request. It also routes a source to the transfer controller under that same mask, where a design that masked the transfer path would drop the trigger, or would leak the routed source onto the CPU vector. With every source cleared, a design that reset the vector instead of holding it shows up at once. Long runs of random flags, enables, levels and routing are compared every cycle against a behavioural model.

// File: rtl/pic_pkg.sv
package pic_pkg;
    // default source population: one software source plus peripheral sources
    localparam int PIC_NUM_SRC     = 39;
    localparam int PIC_SRC_PER_MOD = 4;
endpackage

// File: rtl/pic_src_qualify.sv
module pic_src_qualify #(
    parameter int NUM_SRC     = 39,
    parameter int SRC_PER_MOD = 4,
    parameter int NUM_MOD     = (NUM_SRC + SRC_PER_MOD - 1) / SRC_PER_MOD
) (
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] xfer_sel,
    input  logic [NUM_MOD-1:0] mod_level,
    input  logic               cpu_mask,
    output logic [NUM_SRC-1:0] cand_hi,
    output logic [NUM_SRC-1:0] cand_lo,
    output logic [NUM_SRC-1:0] xfer_hit
);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        localparam int MOD_IDX = i / SRC_PER_MOD;
        logic pend;
        logic to_cpu;
        assign pend        = src_flag[i] & src_en[i];
        assign to_cpu      = pend & ~xfer_sel[i];
        assign cand_hi[i]  = to_cpu & mod_level[MOD_IDX];
        assign cand_lo[i]  = to_cpu & ~mod_level[MOD_IDX] & ~cpu_mask;
        assign xfer_hit[i] = pend & xfer_sel[i];
    end
endmodule

// File: rtl/pic_prio_pick.sv
module pic_prio_pick #(
    parameter int N = 39,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] cand,
    output logic         found,
    output logic [W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = W'(i);
            end
        end
    end
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int NUM_SRC     = PIC_NUM_SRC,
    parameter int SRC_PER_MOD = PIC_SRC_PER_MOD,
    parameter int NUM_MOD     = (NUM_SRC + SRC_PER_MOD - 1) / SRC_PER_MOD,
    parameter int VEC_W       = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic [NUM_SRC-1:0] xfer_sel,
    input  logic [NUM_MOD-1:0] mod_level,
    input  logic               cpu_mask,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [NUM_SRC-1:0] xfer_trig
);
    typedef struct packed {
        logic               req;
        logic [VEC_W-1:0]   vec;
        logic [NUM_SRC-1:0] trig;
    } pic_state_t;

    pic_state_t st_d, st_q;

    logic [NUM_SRC-1:0] cand_hi, cand_lo, xfer_hit;
    logic               hi_found, lo_found;
    logic [VEC_W-1:0]   hi_idx, lo_idx;

    pic_src_qualify #(
        .NUM_SRC    (NUM_SRC),
        .SRC_PER_MOD(SRC_PER_MOD),
        .NUM_MOD    (NUM_MOD)
    ) u_qual (
        .src_flag (src_flag),
        .src_en   (src_en),
        .xfer_sel (xfer_sel),
        .mod_level(mod_level),
        .cpu_mask (cpu_mask),
        .cand_hi  (cand_hi),
        .cand_lo  (cand_lo),
        .xfer_hit (xfer_hit)
    );

    pic_prio_pick #(.N(NUM_SRC), .W(VEC_W)) u_pick_hi (
        .cand (cand_hi),
        .found(hi_found),
        .idx  (hi_idx)
    );

    pic_prio_pick #(.N(NUM_SRC), .W(VEC_W)) u_pick_lo (
        .cand (cand_lo),
        .found(lo_found),
        .idx  (lo_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = xfer_hit;
        st_d.req  = hi_found | lo_found;
        if (hi_found) begin
            st_d.vec = hi_idx;
        end else if (lo_found) begin
            st_d.vec = lo_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_req   = st_q.req;
    assign irq_vec   = st_q.vec;
    assign xfer_trig = st_q.trig;

    logic [NUM_SRC-1:0] cand_all;
    assign cand_all = cand_hi | cand_lo;

    AST_VEC_WAS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((($past(cand_all) >> irq_vec) & 1) != 0)); // R2
    AST_NOT_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((($past(xfer_sel) >> irq_vec) & 1) == 0)); // R6
    AST_MASK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && $past(cpu_mask)) |-> ((($past(mod_level) >> (irq_vec / SRC_PER_MOD)) & 1) != 0)); // R5
    AST_HI_BEATS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ($past(cand_hi) != '0)) |-> ((($past(mod_level) >> (irq_vec / SRC_PER_MOD)) & 1) != 0)); // R3
    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> $stable(irq_vec)); // R9
    AST_TRIG_ROUTED: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_trig & ~$past(src_flag & src_en & xfer_sel)) == '0); // R7
endmodule

// File: tb/pic_top_tb.sv
module pic_top_tb;
    localparam int NS = 39;
    localparam int PM = 4;
    localparam int NM = (NS + PM - 1) / PM;
    localparam int VW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] src_flag = '0, src_en = '0, xfer_sel = '0;
    logic [NM-1:0] mod_level = '0;
    logic          cpu_mask = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic [NS-1:0] xfer_trig;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    int            exp_vec = 0;
    bit            exp_req = 0;
    logic [NS-1:0] exp_trig = '0;

    always #10 clk = ~clk;

    pic_top u_dut (
        .clk(clk), .rst_n(rst_n), .src_flag(src_flag), .src_en(src_en),
        .xfer_sel(xfer_sel), .mod_level(mod_level), .cpu_mask(cpu_mask),
        .irq_req(irq_req), .irq_vec(irq_vec), .xfer_trig(xfer_trig)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: the best (level, -index) pair wins
    task automatic model();
        int best = -1;
        int best_lvl = -1;
        for (int i = 0; i < NS; i++) begin
            int lvl = mod_level[i / PM];
            if (src_flag[i] && src_en[i]) begin
                exp_trig[i] = xfer_sel[i];
                if (!xfer_sel[i] && (!cpu_mask || lvl == 1) && lvl > best_lvl) begin
                    best = i;
                    best_lvl = lvl;
                end
            end else begin
                exp_trig[i] = 1'b0;
            end
        end
        exp_req = (best >= 0);
        if (best >= 0) exp_vec = best;
    endtask

    // one clock: model inputs at the edge, compare at the following falling edge
    task automatic step(input string tag);
        @(posedge clk);
        model();
        @(negedge clk);
        chk({tag, " req"}, int'(irq_req), int'(exp_req));
        chk({tag, " vec"}, int'(irq_vec), exp_vec);
        n_run++;
        if (xfer_trig !== exp_trig) begin
            n_fail++;
            $display("FAIL %s trig actual=%h expected=%h", tag, xfer_trig, exp_trig);
        end
    endtask

    task automatic clear();
        src_flag = '0; src_en = '0; xfer_sel = '0; mod_level = '0; cpu_mask = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", int'(irq_req), 0);
        chk("R1 vec in reset", int'(irq_vec), 0);
        chk("R1 trig in reset", int'(xfer_trig != '0), 0);
        rst_n = 1'b1;
        step("R1");

        // R2: flag alone, enable alone
        src_flag[7] = 1;
        step("R2 flag only");
        src_flag = '0; src_en[7] = 1;
        step("R2 enable only");
        src_flag[7] = 1;
        #1 chk("R8 no change before edge", int'(irq_req), 0);
        step("R2 both set");
        chk("R2 vec 7", int'(irq_vec), 7);

        // R4: lowest index wins, across modules and within one
        clear();
        src_flag[5] = 1; src_en[5] = 1; src_flag[20] = 1; src_en[20] = 1;
        step("R4 across modules");
        chk("R4 vec 5", int'(irq_vec), 5);
        clear();
        src_flag[9] = 1; src_en[9] = 1; src_flag[8] = 1; src_en[8] = 1;
        step("R4 within module");
        chk("R4 vec 8", int'(irq_vec), 8);

        // R3: level-1 module beats lower index
        mod_level[4] = 1; src_flag[17] = 1; src_en[17] = 1; src_flag[3] = 1; src_en[3] = 1;
        step("R3 level wins");
        chk("R3 vec 17", int'(irq_vec), 17);

        // R5: mask blocks level-0
        clear();
        cpu_mask = 1; src_flag[3] = 1; src_en[3] = 1;
        step("R5 mask blocks");
        chk("R5 req low", int'(irq_req), 0);
        mod_level[9] = 1; src_flag[38] = 1; src_en[38] = 1;
        step("R5 mask passes level1");
        chk("R5 vec 38", int'(irq_vec), 38);

        // R6/R7: routed source under mask
        clear();
        cpu_mask = 1; xfer_sel[3] = 1; src_flag[3] = 1; src_en[3] = 1;
        step("R7 trig under mask");
        chk("R7 trig bit3", int'(xfer_trig[3]), 1);
        cpu_mask = 0;
        step("R6 routed not on cpu");
        chk("R6 req low", int'(irq_req), 0);

        // R9: hold vector
        clear();
        src_flag[12] = 1; src_en[12] = 1;
        step("R9 setup");
        clear();
        step("R9 hold");
        chk("R9 vec held 12", int'(irq_vec), 12);

        // random mix, full model comparison
        for (int k = 0; k < 400; k++) begin
            src_flag  = {$urandom, $urandom};
            src_en    = {$urandom, $urandom};
            xfer_sel  = {$urandom, $urandom} & {$urandom, $urandom};
            mod_level = NM'($urandom);
            cpu_mask  = $urandom_range(0, 1);
            if ((k % 4) == 0) src_en = src_en & {$urandom, $urandom} & {$urandom, $urandom};
            if ((k % 7) == 0) src_flag = '0;
            step("R3 R4 R5 random");
        end
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule